// File: doc/BRIEF.md
# Event Status and Interrupt Mask Register Bank

This block gathers five timekeeping event pulses (update acknowledge, alarm, second tick, time event, calendar event) into a sticky status word. It combines that word with an interrupt mask to drive a single registered, level-sensitive interrupt line. Software reads the status word and the mask together to find which source raised the line.

Software never writes the status word or the mask directly. A status bit is cleared by writing a one to its position in a separate clear-command register. A mask bit is set through an enable register and cleared through a disable register, and in both cases zero bits are left alone. This allows one source to be enabled, disabled or acknowledged without a read-modify-write that could race against another source.

The bus side is a simple single-cycle register port. Writes take effect at the clock edge on which the write strobe is sampled. Read data is a combinational function of the address and the current register state.

Top module: `rtc_irq_bank`

## Requirements
- R1: An event input pulse sets the matching status bit at the next clock edge, and the bit then stays set until cleared. At offset 0x18, status reads back with update acknowledge in bit 0, alarm in bit 1, second tick in bit 2, time event in bit 3 and calendar event in bit 4.
- R2: A write to offset 0x1C clears every status bit whose data bit is one and leaves status bits whose data bit is zero unchanged.
- R3: When an event and a clear of the same status bit fall on the same clock edge, the bit ends up set.
- R4: A write to offset 0x20 sets every mask bit whose data bit is one, and zero data bits leave the mask unchanged.
- R5: A write to offset 0x24 clears every mask bit whose data bit is one, and zero data bits leave the mask unchanged.
- R6: The mask reads back at offset 0x28 in the same bit positions as status, and it is all zero after reset.
- R7: The interrupt output is high exactly one clock after a cycle in which some status bit and its mask bit are both set, and low one clock after a cycle in which none are.
- R8: Reads of the write-only offsets 0x1C, 0x20 and 0x24 return zero, and so does every offset other than 0x18 and 0x28. Read data bits above bit 4 are always zero.
- R9: Writes to the read-only offsets 0x18 and 0x28, and to any offset outside 0x1C, 0x20 and 0x24, change neither status nor mask.
- R10: A synchronous reset clears status, mask and the interrupt output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_in | input | 5 | Event pulses, one bit per source, in status bit order |
| bus_addr | input | 8 | Register byte offset for reads and writes |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| irq | output | 1 | Registered level interrupt |

## Verification
Two pairs of functions can meet on one clock edge: an event pulse together with a clear-command write to the same bit, and an enable or clear write together with a pending status bit that is about to assert the interrupt. The bench drives each pair on the same edge on purpose and also mixes them with unrelated bit positions. A cycle-accurate behavioural model predicts the status word, the mask and the interrupt level, and these predictions are compared on every cycle. The result is judged by reading status back and by watching whether the interrupt rises or falls one clock later.

// File: rtl/rtc_irq_pkg.sv
package rtc_irq_pkg;
    localparam int EVT_COUNT = 5;

    // Register byte offsets decoded by this bank
    localparam logic [7:0] OFF_STATUS = 8'h18;
    localparam logic [7:0] OFF_CLEAR  = 8'h1C;
    localparam logic [7:0] OFF_ENABLE = 8'h20;
    localparam logic [7:0] OFF_DISABLE= 8'h24;
    localparam logic [7:0] OFF_MASK   = 8'h28;

    typedef enum logic [1:0] {
        RSEL_NONE   = 2'd0,
        RSEL_STATUS = 2'd1,
        RSEL_MASK   = 2'd2
    } rsel_e;

    typedef struct packed {
        logic clear;
        logic enable;
        logic disable_;
    } wr_strobe_t;

    function automatic wr_strobe_t decode_write(input logic wr, input logic [7:0] addr);
        wr_strobe_t s;
        s.clear    = wr && (addr == OFF_CLEAR);
        s.enable   = wr && (addr == OFF_ENABLE);
        s.disable_ = wr && (addr == OFF_DISABLE);
        return s;
    endfunction

    function automatic rsel_e decode_read(input logic [7:0] addr);
        if (addr == OFF_STATUS) return RSEL_STATUS;
        if (addr == OFF_MASK)   return RSEL_MASK;
        return RSEL_NONE;
    endfunction
endpackage

// File: rtl/rib_decode.sv
module rib_decode
    import rtc_irq_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int N_EVT  = EVT_COUNT
) (
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [N_EVT-1:0]  clr_bits,
    output logic [N_EVT-1:0]  set_mask,
    output logic [N_EVT-1:0]  clr_mask,
    output rsel_e             rsel
);
    localparam int AW8 = (ADDR_W < 8) ? ADDR_W : 8;

    logic [7:0]  addr8;
    wr_strobe_t  strb;
    logic        high_zero;

    always_comb begin
        addr8 = '0;
        addr8[AW8-1:0] = bus_addr[AW8-1:0];
    end

    generate
        if (ADDR_W > 8) begin : g_wide
            assign high_zero = (bus_addr[ADDR_W-1:8] == '0);
        end else begin : g_narrow
            assign high_zero = 1'b1;
        end
    endgenerate

    always_comb begin
        strb     = decode_write(bus_wr && high_zero, addr8);
        rsel     = high_zero ? decode_read(addr8) : RSEL_NONE;
        clr_bits = strb.clear    ? bus_wdata[N_EVT-1:0] : '0;
        set_mask = strb.enable   ? bus_wdata[N_EVT-1:0] : '0;
        clr_mask = strb.disable_ ? bus_wdata[N_EVT-1:0] : '0;
    end
endmodule

// File: rtl/rib_status.sv
module rib_status #(
    parameter int N_EVT = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_EVT-1:0] evt,
    input  logic [N_EVT-1:0] clr_bits,
    output logic [N_EVT-1:0] status_q
);
    always_ff @(posedge clk) begin
        if (rst) status_q <= '0;
        else     status_q <= (status_q & ~clr_bits) | evt;
    end

    assert_evt_sets_R1: assert property (@(posedge clk) disable iff (rst)
        (evt != '0) |=> ((status_q & $past(evt)) == $past(evt)));

    assert_sticky_R1: assert property (@(posedge clk) disable iff (rst)
        ((status_q & ~clr_bits) != '0) |=>
            ((status_q & $past(status_q & ~clr_bits)) == $past(status_q & ~clr_bits)));

    assert_clear_R2: assert property (@(posedge clk) disable iff (rst)
        ((clr_bits & ~evt) != '0) |=> ((status_q & $past(clr_bits & ~evt)) == '0));

    assert_collide_R3: assert property (@(posedge clk) disable iff (rst)
        ((clr_bits & evt) != '0) |=> ((status_q & $past(clr_bits & evt)) == $past(clr_bits & evt)));
endmodule

// File: rtl/rib_mask.sv
module rib_mask #(
    parameter int N_EVT = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_EVT-1:0] set_bits,
    input  logic [N_EVT-1:0] clr_bits,
    output logic [N_EVT-1:0] mask_q
);
    always_ff @(posedge clk) begin
        if (rst) mask_q <= '0;
        else     mask_q <= (mask_q | set_bits) & ~clr_bits;
    end

    assert_enable_R4: assert property (@(posedge clk) disable iff (rst)
        (set_bits != '0) |=> ((mask_q & $past(set_bits)) == $past(set_bits)));

    assert_disable_R5: assert property (@(posedge clk) disable iff (rst)
        (clr_bits != '0) |=> ((mask_q & $past(clr_bits)) == '0));

    assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
        ((set_bits == '0) && (clr_bits == '0)) |=> $stable(mask_q));

    assert_reset_R6: assert property (@(posedge clk)
        $past(rst) |-> (mask_q == '0));
endmodule

// File: rtl/rtc_irq_bank.sv
module rtc_irq_bank
    import rtc_irq_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int N_EVT  = EVT_COUNT
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N_EVT-1:0]  evt_in,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);
    logic [N_EVT-1:0] clr_bits, set_mask, clr_mask;
    logic [N_EVT-1:0] status_q, mask_q;
    rsel_e            rsel;
    logic             irq_q;

    rib_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .N_EVT(N_EVT)) u_decode (
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .clr_bits (clr_bits),
        .set_mask (set_mask),
        .clr_mask (clr_mask),
        .rsel     (rsel)
    );

    rib_status #(.N_EVT(N_EVT)) u_status (
        .clk     (clk),
        .rst     (rst),
        .evt     (evt_in),
        .clr_bits(clr_bits),
        .status_q(status_q)
    );

    rib_mask #(.N_EVT(N_EVT)) u_mask (
        .clk     (clk),
        .rst     (rst),
        .set_bits(set_mask),
        .clr_bits(clr_mask),
        .mask_q  (mask_q)
    );

    always_comb begin
        bus_rdata = '0;
        unique case (rsel)
            RSEL_STATUS: bus_rdata[N_EVT-1:0] = status_q;
            RSEL_MASK:   bus_rdata[N_EVT-1:0] = mask_q;
            default:     bus_rdata = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) irq_q <= 1'b0;
        else     irq_q <= |(status_q & mask_q);
    end
    assign irq = irq_q;

    assert_irq_rise_R7: assert property (@(posedge clk) disable iff (rst)
        ((status_q & mask_q) != '0) |=> irq);

    assert_irq_fall_R7: assert property (@(posedge clk) disable iff (rst)
        ((status_q & mask_q) == '0) |=> !irq);

    assert_wo_read_R8: assert property (@(posedge clk) disable iff (rst)
        ((bus_addr == ADDR_W'(OFF_CLEAR)) || (bus_addr == ADDR_W'(OFF_ENABLE)) ||
         (bus_addr == ADDR_W'(OFF_DISABLE))) |-> (bus_rdata == '0));

    assert_ro_write_R9: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && (evt_in == '0) && ((bus_addr == ADDR_W'(OFF_STATUS)) ||
         (bus_addr == ADDR_W'(OFF_MASK)))) |=> ($stable(status_q) && $stable(mask_q)));

    assert_reset_R10: assert property (@(posedge clk)
        $past(rst) |-> (!irq && (status_q == '0)));
endmodule

// File: tb/rtc_irq_bank_tb.sv
module rtc_irq_bank_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [4:0]  evt_in = '0;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int errors = 0;
    int checks = 0;
    string tag = "R10";
    bit done = 1'b0;

    // behavioural reference model
    int m_stat = 0;
    int m_mask = 0;
    int m_irq  = 0;

    always #2.5 clk = ~clk;

    rtc_irq_bank u_dut (
        .clk(clk), .rst(rst), .evt_in(evt_in), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    always @(posedge clk) begin
        if (rst) begin
            m_stat = 0; m_mask = 0; m_irq = 0;
        end else begin
            int w;
            w = int'(bus_wdata[4:0]);
            m_irq = ((m_stat & m_mask) != 0) ? 1 : 0;
            if (bus_wr && bus_addr == 8'h1C) m_stat = m_stat & ~w;
            m_stat = m_stat | int'(evt_in);
            if (bus_wr && bus_addr == 8'h20) m_mask = m_mask | w;
            if (bus_wr && bus_addr == 8'h24) m_mask = m_mask & ~w;
        end
    end

    function automatic int exp_rdata(input logic [7:0] a);
        if (a == 8'h18) return m_stat;
        if (a == 8'h28) return m_mask;
        return 0;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h (addr 0x%0h)", req, act, exp, bus_addr);
        end
    endtask

    // compare at the negedge, then drive the next cycle's inputs
    task automatic step(input logic wr, input logic [7:0] a, input logic [31:0] d, input logic [4:0] e);
        @(negedge clk);
        if (!rst) begin
            check(tag, int'(irq), m_irq);
            check(tag, int'(bus_rdata), exp_rdata(bus_addr));
        end
        bus_wr = wr; bus_addr = a; bus_wdata = d; evt_in = e;
    endtask

    task automatic idle(input logic [7:0] a);
        step(1'b0, a, 32'h0, 5'h0);
    endtask

    initial begin
        #(5 * 200000);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R10 / R6: reset state
        tag = "R10"; idle(8'h18); idle(8'h28);
        tag = "R6";  idle(8'h28); idle(8'h28);

        // R1: each source sets its own bit and sticks
        tag = "R1";
        for (int i = 0; i < 5; i++) begin
            step(1'b0, 8'h18, 32'h0, 5'(1 << i));
            idle(8'h18); idle(8'h18);
        end

        // R2: clear a subset, zeros leave bits alone
        tag = "R2";
        step(1'b1, 8'h1C, 32'h0000_0005, 5'h0);
        idle(8'h18);
        step(1'b1, 8'h1C, 32'hFFFF_FFE0, 5'h0);
        idle(8'h18);

        // R3: event and clear of the same bit on one edge
        tag = "R3";
        step(1'b1, 8'h1C, 32'h0000_0004, 5'h04);
        idle(8'h18);
        step(1'b1, 8'h1C, 32'h0000_001F, 5'h01);
        idle(8'h18); idle(8'h18);

        // R4: enable sets only the ones
        tag = "R4";
        step(1'b1, 8'h20, 32'h0000_0006, 5'h0);
        idle(8'h28);
        step(1'b1, 8'h20, 32'h0, 5'h0);
        idle(8'h28);

        // R5: disable clears only the ones
        tag = "R5";
        step(1'b1, 8'h24, 32'h0000_0004, 5'h0);
        idle(8'h28);
        step(1'b1, 8'h24, 32'h0, 5'h0);
        idle(8'h28);

        // R7: interrupt follows status and mask one clock later
        tag = "R7";
        step(1'b0, 8'h18, 32'h0, 5'h02);
        idle(8'h18); idle(8'h18); idle(8'h18);
        step(1'b1, 8'h1C, 32'h0000_0002, 5'h0);
        idle(8'h18); idle(8'h18);
        step(1'b1, 8'h20, 32'h0000_0001, 5'h01);
        idle(8'h28); idle(8'h28);
        step(1'b1, 8'h24, 32'h0000_001F, 5'h10);
        idle(8'h18); idle(8'h18);
        step(1'b1, 8'h20, 32'h0000_0010, 5'h0);
        idle(8'h18); idle(8'h18);

        // R8: write-only and unused offsets read zero
        tag = "R8";
        idle(8'h1C); idle(8'h20); idle(8'h24);
        idle(8'h00); idle(8'h08); idle(8'h2C); idle(8'h19); idle(8'hFF);

        // R9: writes to read-only and unused offsets are ignored
        tag = "R9";
        step(1'b1, 8'h18, 32'hFFFF_FFFF, 5'h0);
        idle(8'h18);
        step(1'b1, 8'h28, 32'hFFFF_FFFF, 5'h0);
        idle(8'h28);
        step(1'b1, 8'h08, 32'hFFFF_FFFF, 5'h0);
        idle(8'h18); idle(8'h28);
        step(1'b1, 8'h2C, 32'hFFFF_FFFF, 5'h0);
        idle(8'h18); idle(8'h28);

        // R10: reset in the middle of activity
        tag = "R10";
        step(1'b1, 8'h20, 32'h0000_001F, 5'h1F);
        idle(8'h18); idle(8'h18);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        bus_addr = 8'h18;
        @(negedge clk);
        check("R10", int'(irq), 0);
        check("R10", int'(bus_rdata), 0);
        bus_addr = 8'h28;
        #0.5;
        check("R10", int'(bus_rdata), 0);
        idle(8'h28); idle(8'h18);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule